// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter

This block turns the single-bit stream of a delta-sigma modulator into signed conversion results. Three integrators run at the modulator rate. Three differentiators (combs) run once per output period. Together they give a (sin x / x)^3 response with notches at whole multiples of the output rate. The filter also produces the modulator clock enable: a phase accumulator adds a step of 1, 2, 4, 8 or 16 to a `2^PRE_W`-wide register on every system clock, and each carry is one modulator tick. With the default `PRE_W = 9`, the tick rate is the system clock times the step divided by 512.

A programmable ratio `decimN` sets the output period to `decimN + 1` modulator ticks. Each published result is weighted over the last three periods. After a restart, or after any change to `decimN` or the rate code, the block clears its state and holds results back until its memory holds only new samples. A separate marker input tells the filter that the analog input has changed. The settled flag then stays low until no result mixes old and new input. Three boundaries are enough when the change lines up with the start of a period. Four are needed when it does not.

Top module: `sinc3_decimator`

## Requirements
- R1: `modTick` is high for one clock once every `2^PRE_W / 2^min(turboCode,4)` clocks, so rate codes 0..4 select ×1, ×2, ×4, ×8, ×16, and every larger code acts like code 4. `modBit` and `changeMark` are consumed only on clocks where `modTick` is high.
- R2: Ticks are numbered from 0 after a restart. Tick k is an output boundary when `k mod (decimN+1) == decimN`.
- R3: A published result equals sum over j of h[j]·s[t−j], in two's complement on `OUT_W = 3·DEC_W+2` bits. Here t is the boundary tick, s is +1 for a sampled 1 and −1 for a sampled 0, and h[j] (j = 0..3·(decimN+1)−3) counts the ways j can be written as a sum of three integers, each in 0..decimN.
- R4: `resultValid` is a single-clock pulse in the clock after a boundary tick. The first two boundaries after a restart publish nothing, so the third is the first valid result.
- R5: A high `restart` suppresses `modTick` in that clock. It clears the tick accumulator, the period phase, the integrators, the combs and the warm-up and settling counts.
- R6: A change of `decimN` or `turboCode` has the same effect as a `restart` pulse in the clock where the new value appears.
- R7: The first valid result after a restart has `resultSettled` high.
- R8: A `changeMark` consumed on a tick whose period phase is 0 makes `resultSettled` low on the boundaries until the third boundary after that tick. That third boundary is settled. A boundary on the marked tick itself does not count.
- R9: A `changeMark` consumed on a tick with any other phase needs four later boundaries before `resultSettled` rises.
- R10: `resultData` changes only in the clock after a tick, and it holds its value in every clock without a valid pulse. `resultSettled` is low whenever `resultValid` is low.
- R11: While `rstN` is low, `modTick`, `resultValid` and `resultSettled` are low and `resultData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Clears filter state and restarts warm-up |
| decimN | input | DEC_W | Decimation setting; period is decimN+1 ticks |
| turboCode | input | TURBO_W | Oversampling code, log2 of the tick multiplier |
| changeMark | input | 1 | Marks an analog input change on the current tick |
| modBit | input | 1 | Modulator output bit, taken on ticks |
| modTick | output | 1 | Modulator clock enable |
| resultData | output | 3·DEC_W+2 | Signed conversion result |
| resultValid | output | 1 | One-clock strobe for a new result |
| resultSettled | output | 1 | Result is free of pre-change input |

## Verification
Every decimation setting from 0 to 7 is run at the fastest tick rate with all-zero, all-one, slowly alternating, sparse and pseudo-random bit streams. Constant streams pin the extreme values ±(decimN+1)^3 and the overall scale. The alternating, sparse and random streams check that each kernel weight lands on the right sample, because a kernel shifted by one tick or cut at the wrong length gives a different sum. A sweep over all rate codes measures the gap between ticks and shows both the clamp above code 4 and the warm-up count at each rate. Change markers placed at phase 0, mid-period and on a boundary tick separate the three-boundary case from the four-boundary case.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;
  // Filter order: the settle rules below depend on it being three.
  localparam int ORDER = 3;
  // Largest supported log2 tick multiplier (x16).
  localparam int TURBO_MAX_LOG = 4;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic clear;    // wipe integrators and comb delays
    logic tick;     // modulator sample is taken this clock
    logic dump;     // tick is the last of an output period
    logic publish;  // dump whose result leaves the block
  } filtStrobe_t;
endpackage

// File: rtl/sinc3_ctrl.sv
`timescale 1ns/1ps
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int DEC_W   = 8,
  parameter int PRE_W   = 9,
  parameter int TURBO_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic [DEC_W-1:0]   decimN,
  input  logic [TURBO_W-1:0] turboCode,
  input  logic               changeMark,
  output logic               modTick,
  output filtStrobe_t        strobe,
  output logic               resultValid,
  output logic               resultSettled
);
  localparam int SUM_W = PRE_W + 1;
  localparam int CFG_W = DEC_W + TURBO_W;

  logic [CFG_W-1:0] cfgQ;
  logic [CFG_W-1:0] cfgNow;
  logic [PRE_W-1:0] accQ;
  logic [SUM_W-1:0] stepSize;
  logic [SUM_W-1:0] accSum;
  logic [DEC_W-1:0] phaseQ;
  logic [1:0]       warmCnt;
  logic [2:0]       settleCnt;
  logic [2:0]       needLoad;
  logic             clearNow;
  logic             tickNow;
  logic             atBoundary;
  logic             dumpNow;
  logic             warmDone;
  logic             publishNow;
  logic             validQ;
  logic             settledQ;

  assign cfgNow = {decimN, turboCode};

  always_comb begin
    if (turboCode > TURBO_W'(TURBO_MAX_LOG)) stepSize = SUM_W'(1) << TURBO_MAX_LOG;
    else                                     stepSize = SUM_W'(1) << turboCode;
  end

  assign accSum     = {1'b0, accQ} + stepSize;
  assign clearNow   = restart | (cfgNow != cfgQ);
  assign tickNow    = rstN & accSum[PRE_W] & ~clearNow;
  assign atBoundary = (phaseQ == decimN);
  assign dumpNow    = tickNow & atBoundary;
  assign warmDone   = (warmCnt == 2'd0);
  assign publishNow = dumpNow & warmDone;
  assign needLoad   = (phaseQ == '0) ? 3'd3 : 3'd4;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ      <= '0;
      accQ      <= '0;
      phaseQ    <= '0;
      warmCnt   <= 2'd2;
      settleCnt <= 3'd3;
      validQ    <= 1'b0;
      settledQ  <= 1'b0;
    end else begin
      cfgQ     <= cfgNow;
      validQ   <= publishNow;
      settledQ <= publishNow & ~changeMark & (settleCnt <= 3'd1);
      if (clearNow) begin
        accQ      <= '0;
        phaseQ    <= '0;
        warmCnt   <= 2'd2;
        settleCnt <= 3'd3;
      end else begin
        accQ <= accSum[PRE_W-1:0];
        if (tickNow) begin
          phaseQ <= atBoundary ? '0 : phaseQ + DEC_W'(1);
          if (dumpNow && !warmDone) warmCnt <= warmCnt - 2'd1;
          if (changeMark)                          settleCnt <= needLoad;
          else if (dumpNow && settleCnt != 3'd0)   settleCnt <= settleCnt - 3'd1;
        end
      end
    end
  end

  assign modTick        = tickNow;
  assign strobe.clear   = clearNow;
  assign strobe.tick    = tickNow;
  assign strobe.dump    = dumpNow;
  assign strobe.publish = publishNow;
  assign resultValid    = validQ;
  assign resultSettled  = settledQ;
endmodule

// File: rtl/sinc3_datapath.sv
`timescale 1ns/1ps
module sinc3_datapath
  import sinc3_pkg::*;
#(
  parameter int DEC_W = 8,
  localparam int OUT_W = ORDER * DEC_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modBit,
  input  filtStrobe_t      strobe,
  output logic [OUT_W-1:0] resultData
);
  logic signed [OUT_W-1:0] sample;
  logic signed [OUT_W-1:0] integQ    [ORDER];
  logic signed [OUT_W-1:0] integNext [ORDER];
  logic signed [OUT_W-1:0] combQ     [ORDER];
  logic signed [OUT_W-1:0] combOut   [ORDER];
  logic signed [OUT_W-1:0] resultQ;

  // Bipolar mapping of the modulator bit.
  assign sample = modBit ? OUT_W'(1) : {OUT_W{1'b1}};

  // Cascade: each integrator adds the freshly updated one before it.
  always_comb begin
    integNext[0] = integQ[0] + sample;
    for (int k = 1; k < ORDER; k++) integNext[k] = integQ[k] + integNext[k-1];
    combOut[0] = integNext[ORDER-1] - combQ[0];
    for (int k = 1; k < ORDER; k++) combOut[k] = combOut[k-1] - combQ[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < ORDER; k++) begin
        integQ[k] <= '0;
        combQ[k]  <= '0;
      end
      resultQ <= '0;
    end else if (strobe.clear) begin
      for (int k = 0; k < ORDER; k++) begin
        integQ[k] <= '0;
        combQ[k]  <= '0;
      end
    end else begin
      if (strobe.tick) begin
        for (int k = 0; k < ORDER; k++) integQ[k] <= integNext[k];
      end
      if (strobe.dump) begin
        combQ[0] <= integNext[ORDER-1];
        for (int k = 1; k < ORDER; k++) combQ[k] <= combOut[k-1];
      end
      if (strobe.publish) resultQ <= combOut[ORDER-1];
    end
  end

  assign resultData = resultQ;
endmodule

// File: rtl/sinc3_decimator.sv
`timescale 1ns/1ps
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int DEC_W   = 8,
  parameter int PRE_W   = 9,
  parameter int TURBO_W = 3,
  localparam int OUT_W  = ORDER * DEC_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic [DEC_W-1:0]   decimN,
  input  logic [TURBO_W-1:0] turboCode,
  input  logic               changeMark,
  input  logic               modBit,
  output logic               modTick,
  output logic [OUT_W-1:0]   resultData,
  output logic               resultValid,
  output logic               resultSettled
);
  filtStrobe_t strobe;

  sinc3_ctrl #(.DEC_W(DEC_W), .PRE_W(PRE_W), .TURBO_W(TURBO_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart), .decimN(decimN),
    .turboCode(turboCode), .changeMark(changeMark), .modTick(modTick),
    .strobe(strobe), .resultValid(resultValid), .resultSettled(resultSettled)
  );

  sinc3_datapath #(.DEC_W(DEC_W)) i_data (
    .clk(clk), .rstN(rstN), .modBit(modBit), .strobe(strobe),
    .resultData(resultData)
  );
endmodule

// File: rtl/sinc3_decimator_chk.sv
`timescale 1ns/1ps
module sinc3_decimator_chk #(
  parameter int OUT_W = 26
) (
  input logic             clk,
  input logic             rstN,
  input logic             restart,
  input logic             modTick,
  input logic [OUT_W-1:0] resultData,
  input logic             resultValid,
  input logic             resultSettled
);
  AST_TICK_HELD_IN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> !modTick); // R5
  AST_NO_VALID_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !resultValid); // R4
  AST_VALID_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(modTick)); // R4
  AST_VALID_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R4
  AST_SETTLED_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    resultSettled |-> resultValid); // R10
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(modTick) |-> $stable(resultData)); // R10
endmodule

bind sinc3_decimator sinc3_decimator_chk #(.OUT_W(OUT_W)) i_chk (
  .clk(clk), .rstN(rstN), .restart(restart), .modTick(modTick),
  .resultData(resultData), .resultValid(resultValid), .resultSettled(resultSettled)
);

// File: tb/test_sinc3_decimator.sv
`timescale 1ns/1ps
module test_sinc3_decimator;
  localparam int DEC_W   = 3;
  localparam int PRE_W   = 5;
  localparam int TURBO_W = 3;
  localparam int OUT_W   = 3 * DEC_W + 2;
  localparam int MAXS    = 1024;

  logic clk = 1'b0, rstN = 1'b0, restart = 1'b0, changeMark = 1'b0, modBit = 1'b0;
  logic [DEC_W-1:0]   decimN = '0;
  logic [TURBO_W-1:0] turboCode = '0;
  wire                modTick, resultValid, resultSettled;
  wire [OUT_W-1:0]    resultData;

  always #2.5 clk = ~clk;

  sinc3_decimator #(.DEC_W(DEC_W), .PRE_W(PRE_W), .TURBO_W(TURBO_W)) i_sinc3_decimator (
    .clk(clk), .rstN(rstN), .restart(restart), .decimN(decimN), .turboCode(turboCode),
    .changeMark(changeMark), .modBit(modBit), .modTick(modTick),
    .resultData(resultData), .resultValid(resultValid), .resultSettled(resultSettled)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model state.
  int ker [64];
  bit bits [MAXS];
  int curD, tickIdx, bndCount, bndSince, need, lastT, clkSince, lastResult;
  bit lastWasBnd, haveTick;
  logic [DEC_W+TURBO_W-1:0] prevCfg = '0;
  int patMode = 3, clkCount = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic void resetModel();
    curD = int'(decimN) + 1;
    for (int k = 0; k < 3 * curD - 2; k++) begin
      int c = 0;
      for (int a = 0; a < curD; a++)
        for (int b = 0; b < curD; b++)
          if (k - a - b >= 0 && k - a - b < curD) c++;
      ker[k] = c;
    end
    tickIdx = 0; bndCount = 0; bndSince = 0; need = 3;
    lastWasBnd = 0; haveTick = 0; clkSince = 0;
  endfunction

  function automatic int expectedAt(int t);
    int s = 0;
    for (int k = 0; k < 3 * curD - 2; k++)
      s += bits[t - k] ? ker[k] : -ker[k];
    return s;
  endfunction

  function automatic int tickGap();
    int c = int'(turboCode);
    if (c > 4) c = 4;
    return (1 << PRE_W) >> c;
  endfunction

  // Monitor: samples at the falling edge.
  always @(negedge clk) begin
    int act;
    act = $signed(resultData);
    if (!done) begin
      if (!rstN) begin
        check(resultValid == 0 && resultSettled == 0 && modTick == 0 && act == 0,
              "R11 reset outputs", act, 0);
        prevCfg = {decimN, turboCode};
        resetModel();
      end else if (restart || {decimN, turboCode} != prevCfg) begin
        check(modTick == 0, restart ? "R5 tick held in restart" : "R6 tick held on config change",
              int'(modTick), 0);
        prevCfg = {decimN, turboCode};
        resetModel();
      end else begin
        check(resultValid == (lastWasBnd && bndCount >= 3), "R2/R4 valid timing",
              int'(resultValid), int'(lastWasBnd && bndCount >= 3));
        if (resultValid) begin
          check(act == expectedAt(lastT), "R3 result value", act, expectedAt(lastT));
          check(resultSettled == (bndSince >= need),
                need == 4 ? "R9 settled after unaligned change" : "R7/R8 settled flag",
                int'(resultSettled), int'(bndSince >= need));
          lastResult = act;
        end else begin
          check(act == lastResult && resultSettled == 0, "R10 hold between results",
                act, lastResult);
        end
        lastWasBnd = 0;
        clkSince++;
        if (modTick) begin
          if (haveTick) check(clkSince == tickGap(), "R1 tick spacing", clkSince, tickGap());
          haveTick = 1;
          clkSince = 0;
          if (tickIdx < MAXS) bits[tickIdx] = modBit;
          if (tickIdx % curD == curD - 1) begin
            bndCount++;
            lastWasBnd = 1;
            lastT = tickIdx;
            if (!changeMark && bndSince < 100) bndSince++;
          end
          if (changeMark) begin
            bndSince = 0;
            need = (tickIdx % curD == 0) ? 3 : 4;
          end
          tickIdx++;
        end
      end
    end
  end

  // Bit stream generator, drives after the rising edge.
  initial forever begin
    @(posedge clk); #1;
    clkCount++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (patMode)
      0: modBit = 1'b0;
      1: modBit = 1'b1;
      2: modBit = ((clkCount / 3) % 2) == 1;
      4: modBit = (clkCount % 7) < 2;
      default: modBit = lfsr[0];
    endcase
  end

  task automatic waitBnd(input int n);
    while (bndCount < n) begin @(posedge clk); #1; end
    repeat (2) begin @(posedge clk); #1; end
  endtask

  task automatic startRun(input int n, input int code, input int mode, input bit pulse);
    @(posedge clk); #1;
    decimN = DEC_W'(n); turboCode = TURBO_W'(code); patMode = mode; restart = pulse;
    @(posedge clk); #1;
    restart = 1'b0;
  endtask

  task automatic placeChange(input int wantPhase, input int newMode);
    bit placed = 0;
    while (!placed) begin
      @(posedge clk); #1;
      if (modTick && (tickIdx % curD) == wantPhase) begin
        changeMark = 1'b1; patMode = newMode;
        @(posedge clk); #1;
        changeMark = 1'b0;
        placed = 1;
      end
    end
  endtask

  initial begin
    repeat (4) begin @(posedge clk); #1; end
    rstN = 1'b1;
    // R2 R3 R4: every ratio, several streams, explicit restart pulses.
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 5; m++) begin
        startRun(n, 4, m, 1'b1);
        waitBnd(6);
      end
    end
    // R1 R6: all rate codes, restart through config change only.
    for (int c = 0; c < 8; c++) begin
      startRun(2, c, 3, 1'b0);
      waitBnd(5);
    end
    // R8 R9: change markers at several phases.
    startRun(3, 4, 1, 1'b1); waitBnd(4); placeChange(0, 0); waitBnd(bndCount + 5);
    startRun(3, 4, 1, 1'b1); waitBnd(4); placeChange(2, 3); waitBnd(bndCount + 6);
    startRun(3, 4, 0, 1'b1); waitBnd(4); placeChange(3, 1); waitBnd(bndCount + 6);
    startRun(0, 3, 3, 1'b1); waitBnd(4); placeChange(0, 4); waitBnd(bndCount + 5);
    startRun(5, 4, 2, 1'b1); waitBnd(3); placeChange(1, 3); waitBnd(bndCount + 6);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule